// File: doc/BRIEF.md
# FIFO Threshold Offset Register Block

This block holds the two threshold offsets that a FIFO's flag logic compares against its fill level. One offset sets how close to empty the FIFO must be before the almost-empty indication appears. The other sets how close to full it must be before the almost-full indication appears. The FIFO storage and the flag comparators are outside the block. They only read the two offset outputs.

The block samples the load-select input during master reset. That sample sets both offsets to a preset default and fixes the loading method until the next master reset. Load-select low gives a default of 127 and byte-wide parallel loading. Load-select high gives a default of 1,023 and bit-serial loading. Serial loading shifts one bit per clock from a serial data pin while the serial enable is low. Parallel loading writes one byte per clock from the data bus while load-select and write enable are both low. Read-back is available in either method while load-select and read enable are both low. It steps through the same byte sequence using its own pointer. The same sequences serve a FIFO in standard or fall-through mode. Both sides of the block run on a single clock.

Top module: `ofs_regs_if`

## Requirements
- R1: During a clock edge with `rst_n` low, both offsets take the default for the `ld_sel_n` value sampled at that edge. `ld_sel_n` = 0 gives 127 and parallel method. `ld_sel_n` = 1 gives 1023 and serial method.
- R2: The method changes only at a master reset. After reset, changing `ld_sel_n` has no effect on which load path is active.
- R3: In serial method, each edge with `ser_en_n` low stores `ser_bit` into one bit of the combined offset pair. The bit order is almost-empty bit 0 up to its MSB, then almost-full bit 0 up to its MSB. The new bit is visible on the outputs after that edge.
- R4: In parallel method, each edge with `ld_sel_n` and `wr_en_n` both low stores `wdata` into one byte slot. The slot order is almost-empty low byte, almost-empty high byte, almost-full low byte, almost-full high byte.
- R5: The load pointer wraps from the last slot (byte or bit) back to the almost-empty low slot.
- R6: Each edge with `ld_sel_n` and `rd_en_n` both low loads `rdata` with the byte slot under the read pointer, in the R4 slot order. Any data written at that same edge is not included. `rdata` holds its value on all other edges. The read pointer wraps the same way as the load pointer.
- R7: Read-back works the same way when the serial method is selected.
- R8: Parallel write strobes have no effect in serial method. `ser_en_n` has no effect in parallel method.
- R9: The read pointer and the load pointer advance independently. Loads never move the read pointer, and reads never move the load pointer.
- R10: Master reset returns both pointers to the almost-empty low slot and clears `rdata` to 0.
- R11: `wr_en_n` or `rd_en_n` low while `ld_sel_n` is high neither changes the offsets nor changes `rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for loading and read-back |
| rst_n | input | 1 | Synchronous active-low master reset |
| ld_sel_n | input | 1 | Load select, active low. Also picks the default and method at reset |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_bit | input | 1 | Serial data bit |
| wdata | input | BYTE_W | Parallel load byte |
| rdata | output | BYTE_W | Read-back byte |
| ae_offset | output | OFS_W | Almost-empty offset |
| af_offset | output | OFS_W | Almost-full offset |

## Verification
The hardest situation to reach is one where the two pointers are out of step and a load and a read hit the same edge. That edge must return the old contents of the read slot while the write lands elsewhere, or even in the same slot. Seeded random phases reach it by driving load-select, write, read and serial enable independently in both methods, over hundreds of cycles. Directed steps pin down wrap-around, strobes in the wrong method, and a reset that arrives mid-sequence.

// File: rtl/ofs_regs_pkg.sv
// Shared types for the threshold offset register block.
// Assumes nothing beyond a single clock domain for its users.
package ofs_regs_pkg;

    // Loading method latched at master reset
    typedef enum logic {
        OFS_MODE_PAR = 1'b0,
        OFS_MODE_SER = 1'b1
    } ofs_mode_e;

    // Width of a pointer over 'n' slots, never below one bit
    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ofs_wrap_ptr.sv
// Slot pointer that advances by one on each step and wraps to zero
// after LIMIT-1. Used for the serial bit index, the parallel byte
// index and the read-back index.
// Assumes: LIMIT >= 2, synchronous active-low reset.
module ofs_wrap_ptr #(
    parameter int LIMIT = 4,
    localparam int PW = ofs_regs_pkg::ptr_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(LIMIT - 1);

    // Advance with wrap, clear on master reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/ofs_bank.sv
// Storage for the offset pair, kept as one vector with the
// almost-empty offset in the low OFS_W bits. A bit port serves serial
// loading and a byte-slot port serves parallel loading. Each bit picks
// the port that addresses it.
// Assumes: the two write ports are never active together. The top
// gates them by method.
module ofs_bank #(
    parameter int OFS_W   = 16,
    parameter int BYTE_W  = 8,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023,
    localparam int NB     = (OFS_W + BYTE_W - 1) / BYTE_W,
    localparam int NCH    = 2 * NB,
    localparam int NBIT   = 2 * OFS_W,
    localparam int BPW    = ofs_regs_pkg::ptr_width(NBIT),
    localparam int CPW    = ofs_regs_pkg::ptr_width(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_ser,
    input  logic              bit_we,
    input  logic [BPW-1:0]    bit_idx,
    input  logic              bit_val,
    input  logic              byte_we,
    input  logic [CPW-1:0]    byte_idx,
    input  logic [BYTE_W-1:0] byte_val,
    output logic [NBIT-1:0]   ofs_all
);

    localparam logic [OFS_W-1:0] DP = OFS_W'(DEF_PAR);
    localparam logic [OFS_W-1:0] DS = OFS_W'(DEF_SER);

    for (genvar i = 0; i < NBIT; i++) begin : g_bit
        localparam int OI  = i % OFS_W;
        localparam int WHO = i / OFS_W;
        localparam int CH  = WHO * NB + OI / BYTE_W;
        localparam int POS = OI % BYTE_W;
        logic q;

        // One stored bit: default at reset, else serial or parallel write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= rst_ser ? DS[OI] : DP[OI];
            end else if (bit_we && bit_idx == BPW'(i)) begin
                q <= bit_val;
            end else if (byte_we && byte_idx == CPW'(CH)) begin
                q <= byte_val[POS];
            end
        end

        assign ofs_all[i] = q;
    end

endmodule

// File: rtl/ofs_readout.sv
// Read-back register. On each read strobe it captures the byte slot
// named by the pointer. Slot c covers offset c/NB, bits (c%NB)*BYTE_W
// upward. Bits beyond OFS_W read as zero.
// Assumes: ptr < 2*NB. It captures the pre-write contents of the bank.
module ofs_readout #(
    parameter int OFS_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = (OFS_W + BYTE_W - 1) / BYTE_W,
    localparam int NCH   = 2 * NB,
    localparam int NBIT  = 2 * OFS_W,
    localparam int CPW   = ofs_regs_pkg::ptr_width(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CPW-1:0]    ptr,
    input  logic [NBIT-1:0]   ofs_all,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] slot;

    // Select the addressed byte slot out of the offset pair
    always_comb begin
        slot = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ptr == CPW'(c)) begin
                for (int b = 0; b < BYTE_W; b++) begin
                    if ((c % NB) * BYTE_W + b < OFS_W) begin
                        slot[b] = ofs_all[(c / NB) * OFS_W + (c % NB) * BYTE_W + b];
                    end
                end
            end
        end
    end

    // Capture the slot on a read strobe, clear on master reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (go) begin
            rdata <= slot;
        end
    end

endmodule

// File: rtl/ofs_regs_if.sv
// Top of the threshold offset register block. It latches the loading
// method at master reset, routes strobes to the serial or parallel
// load pointer, and runs an independent read-back pointer.
// Assumes: one clock for load and read. All controls are active low
// and sampled synchronously.
module ofs_regs_if #(
    parameter int OFS_W   = 16,
    parameter int BYTE_W  = 8,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_sel_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic              ser_en_n,
    input  logic              ser_bit,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [OFS_W-1:0]  ae_offset,
    output logic [OFS_W-1:0]  af_offset
);

    import ofs_regs_pkg::*;

    localparam int NB   = (OFS_W + BYTE_W - 1) / BYTE_W;
    localparam int NCH  = 2 * NB;
    localparam int NBIT = 2 * OFS_W;
    localparam int BPW  = ptr_width(NBIT);
    localparam int CPW  = ptr_width(NCH);

    ofs_mode_e       mode_q;
    logic            mode_ser;
    logic            ser_go;
    logic            par_go;
    logic            rd_go;
    logic [BPW-1:0]  bit_ptr;
    logic [CPW-1:0]  byte_ptr;
    logic [CPW-1:0]  rd_ptr;
    logic [NBIT-1:0] ofs_all;

    // Latch the loading method only while master reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ld_sel_n ? OFS_MODE_SER : OFS_MODE_PAR;
        end
    end

    // Qualify each strobe with the latched method
    always_comb begin
        mode_ser = (mode_q == OFS_MODE_SER);
        ser_go   = mode_ser && !ser_en_n;
        par_go   = !mode_ser && !ld_sel_n && !wr_en_n;
        rd_go    = !ld_sel_n && !rd_en_n;
    end

    ofs_wrap_ptr #(.LIMIT(NBIT)) u_bit_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ser_go),
        .ptr   (bit_ptr)
    );

    ofs_wrap_ptr #(.LIMIT(NCH)) u_byte_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (par_go),
        .ptr   (byte_ptr)
    );

    ofs_wrap_ptr #(.LIMIT(NCH)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rd_go),
        .ptr   (rd_ptr)
    );

    ofs_bank #(
        .OFS_W   (OFS_W),
        .BYTE_W  (BYTE_W),
        .DEF_PAR (DEF_PAR),
        .DEF_SER (DEF_SER)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_ser  (ld_sel_n),
        .bit_we   (ser_go),
        .bit_idx  (bit_ptr),
        .bit_val  (ser_bit),
        .byte_we  (par_go),
        .byte_idx (byte_ptr),
        .byte_val (wdata),
        .ofs_all  (ofs_all)
    );

    ofs_readout #(
        .OFS_W  (OFS_W),
        .BYTE_W (BYTE_W)
    ) u_readout (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (rd_go),
        .ptr     (rd_ptr),
        .ofs_all (ofs_all),
        .rdata   (rdata)
    );

    // Split the stored pair onto the two offset outputs
    always_comb begin
        ae_offset = ofs_all[OFS_W-1:0];
        af_offset = ofs_all[NBIT-1:OFS_W];
    end

endmodule

// File: rtl/ofs_regs_chk.sv
// Checker for the threshold offset register block, bound to the top.
// It observes ports plus the latched method.
module ofs_regs_chk #(
    parameter int OFS_W   = 16,
    parameter int BYTE_W  = 8,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_sel_n,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic              ser_en_n,
    input logic              mode_ser,
    input logic [BYTE_W-1:0] rdata,
    input logic [OFS_W-1:0]  ae_offset,
    input logic [OFS_W-1:0]  af_offset
);

    // R1
    reset_default_chk: assert property (@(posedge clk)
        !rst_n |=> (ae_offset == ($past(ld_sel_n) ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR)))
                && (af_offset == ($past(ld_sel_n) ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR))));

    // R2
    method_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_ser));

    // R3
    serial_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ser |=> $countones({af_offset, ae_offset} ^ $past({af_offset, ae_offset})) <= 1);

    // R8
    serial_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ser && ser_en_n) |=> ($stable(ae_offset) && $stable(af_offset)));

    // R8
    parallel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ser && (ld_sel_n || wr_en_n)) |=> ($stable(ae_offset) && $stable(af_offset)));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel_n || rd_en_n) |=> $stable(rdata));

endmodule

bind ofs_regs_if ofs_regs_chk #(
    .OFS_W   (OFS_W),
    .BYTE_W  (BYTE_W),
    .DEF_PAR (DEF_PAR),
    .DEF_SER (DEF_SER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_sel_n  (ld_sel_n),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .ser_en_n  (ser_en_n),
    .mode_ser  (mode_ser),
    .rdata     (rdata),
    .ae_offset (ae_offset),
    .af_offset (af_offset)
);

// File: tb/ofs_regs_if_bench.sv
module ofs_regs_if_bench;

    localparam int CLK_P  = 10;
    localparam int OFS_W  = 16;
    localparam int BYTE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_sel_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic              rd_en_n = 1'b1;
    logic              ser_en_n = 1'b1;
    logic              ser_bit = 1'b0;
    logic [BYTE_W-1:0] wdata = '0;
    logic [BYTE_W-1:0] rdata;
    logic [OFS_W-1:0]  ae_offset;
    logic [OFS_W-1:0]  af_offset;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected state, from the requirements
    logic [31:0] m_pair;
    logic [7:0]  m_rd;
    bit          m_ser;
    int          m_wp;
    int          m_rp;

    always #(CLK_P / 2) clk = ~clk;

    ofs_regs_if u_ofs_regs_if (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_sel_n  (ld_sel_n),
        .wr_en_n   (wr_en_n),
        .rd_en_n   (rd_en_n),
        .ser_en_n  (ser_en_n),
        .ser_bit   (ser_bit),
        .wdata     (wdata),
        .rdata     (rdata),
        .ae_offset (ae_offset),
        .af_offset (af_offset)
    );

    function automatic logic [7:0] slot_of(input logic [31:0] v, input int c);
        return v[c*8 +: 8];
    endfunction

    // Expected next state for one edge with the current inputs
    task automatic model_edge();
        if (!rst_n) begin
            m_ser  = ld_sel_n;
            m_pair = ld_sel_n ? {16'd1023, 16'd1023} : {16'd127, 16'd127};
            m_wp   = 0;
            m_rp   = 0;
            m_rd   = 8'h00;
        end else begin
            if (!ld_sel_n && !rd_en_n) begin
                m_rd = slot_of(m_pair, m_rp);
                m_rp = (m_rp + 1) % 4;
            end
            if (m_ser && !ser_en_n) begin
                m_pair[m_wp] = ser_bit;
                m_wp = (m_wp + 1) % 32;
            end else if (!m_ser && !ld_sel_n && !wr_en_n) begin
                m_pair[m_wp*8 +: 8] = wdata;
                m_wp = (m_wp + 1) % 4;
            end
        end
    endtask

    task automatic chk(input string tag);
        checks++;
        if (ae_offset !== m_pair[15:0]) begin
            failures++;
            $display("FAIL %s ae_offset actual=%0d expected=%0d", tag, ae_offset, m_pair[15:0]);
        end
        checks++;
        if (af_offset !== m_pair[31:16]) begin
            failures++;
            $display("FAIL %s af_offset actual=%0d expected=%0d", tag, af_offset, m_pair[31:16]);
        end
        checks++;
        if (rdata !== m_rd) begin
            failures++;
            $display("FAIL %s rdata actual=%0h expected=%0h", tag, rdata, m_rd);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, check after the rise
    task automatic cyc(input logic rst, input logic sel, input logic wr, input logic rd,
                       input logic sen, input logic sb, input logic [7:0] wd, input string tag);
        @(negedge clk);
        rst_n = rst; ld_sel_n = sel; wr_en_n = wr; rd_en_n = rd;
        ser_en_n = sen; ser_bit = sb; wdata = wd;
        @(posedge clk);
        model_edge();
        #1;
        chk(tag);
    endtask

    task automatic idle(input string tag);
        cyc(1, 1, 1, 1, 1, 0, 8'h00, tag);
    endtask

    task automatic rand_phase(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom), tag);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0123));
        // R1: reset with load-select low gives 127 and parallel method
        cyc(0, 0, 1, 1, 1, 0, 8'h00, "R1");
        cyc(0, 0, 1, 1, 1, 0, 8'h00, "R1");
        idle("R1");
        // R4: parallel bytes in slot order
        cyc(1, 0, 0, 1, 1, 0, 8'h11, "R4");
        cyc(1, 0, 0, 1, 1, 0, 8'h22, "R4");
        cyc(1, 0, 0, 1, 1, 0, 8'h33, "R4");
        cyc(1, 0, 0, 1, 1, 0, 8'h44, "R4");
        // R5: fifth byte wraps onto the almost-empty low byte
        cyc(1, 0, 0, 1, 1, 0, 8'h55, "R5");
        // R6: read back in slot order, with wrap
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 1, 0, 8'h00, "R6");
        idle("R6");
        // R11: strobes without load-select do nothing
        cyc(1, 1, 0, 1, 1, 0, 8'hAA, "R11");
        cyc(1, 1, 1, 0, 1, 0, 8'hAA, "R11");
        cyc(1, 1, 0, 0, 1, 0, 8'hAA, "R11");
        // R8: serial enable ignored in parallel method
        for (int i = 0; i < 6; i++) cyc(1, 1, 1, 1, 0, 1, 8'h00, "R8");
        // R2: toggling load-select after reset keeps the parallel method
        cyc(1, 1, 1, 1, 0, 1, 8'h00, "R2");
        cyc(1, 0, 1, 1, 0, 1, 8'h00, "R2");
        cyc(1, 0, 0, 1, 1, 0, 8'h66, "R2");
        // R9: simultaneous read and write, pointers apart
        cyc(1, 0, 0, 0, 1, 0, 8'h77, "R9");
        rand_phase(400, "R9");
        // R10: reset mid-sequence clears pointers
        cyc(1, 0, 0, 1, 1, 0, 8'h12, "R10");
        cyc(0, 0, 1, 1, 1, 0, 8'h00, "R10");
        cyc(1, 0, 0, 1, 1, 0, 8'h9C, "R10");
        cyc(1, 0, 1, 0, 1, 0, 8'h00, "R10");
        // R1: reset with load-select high gives 1023 and serial method
        cyc(0, 1, 1, 1, 1, 0, 8'h00, "R1");
        idle("R1");
        // R7: read-back in serial method, right after reset
        cyc(1, 0, 1, 0, 1, 0, 8'h00, "R7");
        cyc(1, 0, 1, 0, 1, 0, 8'h00, "R7");
        // R3: shift a full 32-bit pattern, then one wrapped bit (R5)
        for (int i = 0; i < 32; i++) cyc(1, 1, 1, 1, 0, (32'hA5C3_0F96 >> i) & 1, 8'h00, "R3");
        cyc(1, 1, 1, 1, 0, 1'b0, 8'h00, "R5");
        // R8: parallel strobes ignored in serial method
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, 1, 0, 8'hFF, "R8");
        // R2: load-select toggles keep the serial method
        cyc(1, 0, 0, 1, 0, 1, 8'h00, "R2");
        // R7: read all four slots
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 1, 0, 8'h00, "R7");
        rand_phase(400, "R9");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule